// File: doc/BRIEF.md
# Packet to Fixed-Chunk Segmenter

This block turns queued transmit work into fixed-size chunk commands for a circular transmit buffer. It pops a buffer handle from a pending queue and reads a three-word descriptor through a simple request/response port. The three words are the buffer address, the packet length and the destination channel. It then cuts the packet into chunks of at most 64 bytes. Each chunk becomes one command on a valid/ready port. The command carries:
- the source address;
- the byte size, and the size in 8-byte words;
- a destination slot in a 128-entry ring;
- start and end flags;
- a packed control word and the slot's control address.

An occupancy tracker compares the chunks it has issued with a hardware transmit sequence counter. It holds issue back while too many chunks are still in the ring. After the final chunk of a packet, the block waits until the completion queue has room. It then pushes the handle there and pulses a host notification. A descriptor with a zero length stops the engine for good.

Top module: `chunk_segmenter`

## Requirements
- R1: For each non-zero handle, the descriptor is read as three words, in this order and at these addresses: handle+0 is the buffer address, handle+4 is the length in bytes, and handle+8 is the channel.
- R2: A handle of zero taken from the pending queue starts no descriptor read, and the engine keeps polling the queue (pend_ready_o stays high).
- R3: A chunk is the last one when the remaining length (length minus offset) is at most 64. The last chunk has size equal to the remaining length and every other chunk has size 64. chk_sop_o is 1 only at offset 0. chk_eop_o is 1 only on the last chunk.
- R4: The chunk source address is the buffer address with its low three bits cleared, plus the current offset. The offset then grows by the chunk size.
- R5: The slot of the first chunk after reset is the low 7 bits of seq_i, sampled in the first cycle after reset. Each later chunk takes the next slot, modulo 128. chk_ctrl_addr_o is 0x1800 + slot*8.
- R6: chk_ctrl_o is the channel OR (flags << 8) OR (size << 24). In the flags, bit 1 is the start flag and bit 0 is the end flag.
- R7: chk_words_o equals (size-1)>>3.
- R8: The in-flight count is the number of issued chunks minus the advance of seq_i since reset, taken modulo 256. A chunk is issued only while this count is at most 96. When seq_i stops advancing, exactly 97 chunks are left in flight, and issue resumes once seq_i advances.
- R9: After a last chunk is accepted, done_valid_o pulses for one cycle with done_handle_o set to that packet's handle. This happens only in a cycle with done_full_i low, and host_irq_o pulses in that same cycle.
- R10: A descriptor whose length word is zero halts the engine. From then on it takes nothing from the pending queue and issues no chunk.
- R11: While rst_ni is low, chk_valid_o, pend_ready_o, desc_req_o, done_valid_o and host_irq_o are all 0.
- R12: While chk_valid_o is high and chk_ready_i is low, the command stays valid and all of its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seq_i | input | 8 | Transmit sequence counter, one step per chunk sent from the ring |
| pend_valid_i | input | 1 | Pending queue has a handle on pend_handle_i |
| pend_handle_i | input | 32 | Buffer handle; zero means no work |
| pend_ready_o | output | 1 | Engine takes the offered handle |
| desc_req_o | output | 1 | Descriptor word read request, held until the response |
| desc_addr_o | output | 32 | Descriptor word address |
| desc_rvalid_i | input | 1 | Read data valid |
| desc_rdata_i | input | 32 | Read data |
| chk_valid_o | output | 1 | Chunk command valid |
| chk_ready_i | input | 1 | Chunk command accepted |
| chk_addr_o | output | 32 | Chunk source address |
| chk_size_o | output | 7 | Chunk size in bytes, 1 to 64 |
| chk_words_o | output | 3 | (size-1)>>3 |
| chk_slot_o | output | 7 | Destination slot in the ring |
| chk_sop_o | output | 1 | Start of packet |
| chk_eop_o | output | 1 | End of packet |
| chk_ctrl_o | output | 32 | Packed control word |
| chk_ctrl_addr_o | output | 16 | Control address of the slot |
| done_full_i | input | 1 | Completion queue full |
| done_valid_o | output | 1 | Push strobe for the completion queue |
| done_handle_o | output | 32 | Handle being pushed |
| host_irq_o | output | 1 | Host notification pulse |

## Verification
A wrong slot counter or offset register shows up at the ports on the very next accepted chunk, as a bad slot, control address, size or source address. The bench compares every field of every chunk handshake against its own model, so such an error is caught within one chunk. A broken occupancy count shows up either as a chunk issued while the model's in-flight count is above 96, or as a stall that settles at some count other than 97 once the sequence input is frozen. A bad descriptor sequence or a missing halt shows up at the descriptor read address, at the pending queue, or as a chunk or completion push in the same cycle it happens.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [3:0] {
    S_INIT, S_POLL, S_RD0, S_RD1, S_RD2, S_WAIT, S_SEND, S_DONE, S_HALT
  } seg_state_e;
endpackage

// File: rtl/seg_occupancy.sv
module seg_occupancy #(
  parameter int SEQ_W  = 8,
  parameter int SLOTS  = 128,
  parameter int THRESH = 96,
  localparam int CNT_W = $clog2(SLOTS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic             issue_i,
  output logic             grant_o
);
  logic [SEQ_W-1:0] seq_q;
  logic [SEQ_W-1:0] delta;
  logic [CNT_W-1:0] inflight_q;

  assign delta   = seq_i - seq_q;
  assign grant_o = (inflight_q <= CNT_W'(THRESH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q      <= '0;
      inflight_q <= '0;
    end else if (init_i) begin
      seq_q      <= seq_i;
      inflight_q <= '0;
    end else begin
      seq_q      <= seq_i;
      inflight_q <= inflight_q - CNT_W'(delta) + CNT_W'(issue_i);
    end
  end

  p_inflight_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CNT_W'(THRESH + 1));
endmodule

// File: rtl/seg_slot_ring.sv
module seg_slot_ring #(
  parameter int SLOTS   = 128,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [SLOT_W-1:0] seed_i,
  input  logic              adv_i,
  output logic [SLOT_W-1:0] slot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     slot_o <= '0;
    else if (init_i) slot_o <= seed_i;
    else if (adv_i)  slot_o <= slot_o + 1'b1;
  end
endmodule

// File: rtl/seg_chunk_calc.sv
module seg_chunk_calc #(
  parameter int          ADDR_W      = 32,
  parameter int          CHUNK_BYTES = 64,
  parameter int          SLOTS       = 128,
  parameter logic [15:0] CTRL_BASE   = 16'h1800,
  localparam int SIZE_W  = $clog2(CHUNK_BYTES) + 1,
  localparam int WORDS_W = $clog2(CHUNK_BYTES / 8),
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [31:0]        len_i,
  input  logic [31:0]        off_i,
  input  logic [31:0]        chan_i,
  input  logic [SLOT_W-1:0]  slot_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [SIZE_W-1:0]  size_o,
  output logic [WORDS_W-1:0] words_o,
  output logic               sop_o,
  output logic               eop_o,
  output logic [31:0]        ctrl_o,
  output logic [15:0]        caddr_o
);
  logic [31:0] rem;

  always_comb begin
    rem     = len_i - off_i;
    eop_o   = (rem <= 32'(CHUNK_BYTES));
    sop_o   = (off_i == '0);
    size_o  = eop_o ? rem[SIZE_W-1:0] : SIZE_W'(CHUNK_BYTES);
    words_o = WORDS_W'((size_o - 1'b1) >> 3);
    addr_o  = base_i + ADDR_W'(off_i);
    ctrl_o  = chan_i | (32'({sop_o, eop_o}) << 8) | (32'(size_o) << 24);
    caddr_o = CTRL_BASE + 16'({slot_i, 3'b000});
  end
endmodule

// File: rtl/chunk_segmenter.sv
module chunk_segmenter #(
  parameter int          ADDR_W      = 32,
  parameter int          CHUNK_BYTES = 64,
  parameter int          SLOTS       = 128,
  parameter int          THRESH      = 96,
  parameter int          SEQ_W       = 8,
  parameter logic [15:0] CTRL_BASE   = 16'h1800,
  localparam int SIZE_W  = $clog2(CHUNK_BYTES) + 1,
  localparam int WORDS_W = $clog2(CHUNK_BYTES / 8),
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEQ_W-1:0]   seq_i,
  input  logic               pend_valid_i,
  input  logic [31:0]        pend_handle_i,
  output logic               pend_ready_o,
  output logic               desc_req_o,
  output logic [31:0]        desc_addr_o,
  input  logic               desc_rvalid_i,
  input  logic [31:0]        desc_rdata_i,
  output logic               chk_valid_o,
  input  logic               chk_ready_i,
  output logic [ADDR_W-1:0]  chk_addr_o,
  output logic [SIZE_W-1:0]  chk_size_o,
  output logic [WORDS_W-1:0] chk_words_o,
  output logic [SLOT_W-1:0]  chk_slot_o,
  output logic               chk_sop_o,
  output logic               chk_eop_o,
  output logic [31:0]        chk_ctrl_o,
  output logic [15:0]        chk_ctrl_addr_o,
  input  logic               done_full_i,
  output logic               done_valid_o,
  output logic [31:0]        done_handle_o,
  output logic               host_irq_o
);
  import seg_pkg::*;

  seg_state_e        state_q, state_d;
  logic [31:0]       handle_q;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       len_q, chan_q, off_q;
  logic              init, fire, grant;

  assign init = (state_q == S_INIT);
  assign fire = chk_valid_o && chk_ready_i;

  seg_occupancy #(.SEQ_W(SEQ_W), .SLOTS(SLOTS), .THRESH(THRESH)) u_occ (
    .clk_i, .rst_ni, .init_i(init), .seq_i, .issue_i(fire), .grant_o(grant)
  );

  seg_slot_ring #(.SLOTS(SLOTS)) u_ring (
    .clk_i, .rst_ni, .init_i(init), .seed_i(seq_i[SLOT_W-1:0]),
    .adv_i(fire), .slot_o(chk_slot_o)
  );

  seg_chunk_calc #(
    .ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES), .SLOTS(SLOTS), .CTRL_BASE(CTRL_BASE)
  ) u_calc (
    .base_i(base_q), .len_i(len_q), .off_i(off_q), .chan_i(chan_q),
    .slot_i(chk_slot_o), .addr_o(chk_addr_o), .size_o(chk_size_o),
    .words_o(chk_words_o), .sop_o(chk_sop_o), .eop_o(chk_eop_o),
    .ctrl_o(chk_ctrl_o), .caddr_o(chk_ctrl_addr_o)
  );

  always_comb begin
    pend_ready_o = (state_q == S_POLL);
    desc_req_o   = 1'b0;
    desc_addr_o  = handle_q;
    unique case (state_q)
      S_RD0:   desc_req_o = 1'b1;
      S_RD1:   begin desc_req_o = 1'b1; desc_addr_o = handle_q + 32'd4; end
      S_RD2:   begin desc_req_o = 1'b1; desc_addr_o = handle_q + 32'd8; end
      default: ;
    endcase
    chk_valid_o   = (state_q == S_SEND);
    done_valid_o  = (state_q == S_DONE) && !done_full_i;
    done_handle_o = handle_q;
    host_irq_o    = done_valid_o;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_INIT: state_d = S_POLL;
      S_POLL: if (pend_valid_i && pend_handle_i != '0) state_d = S_RD0;
      S_RD0:  if (desc_rvalid_i) state_d = S_RD1;
      S_RD1:  if (desc_rvalid_i) state_d = (desc_rdata_i == '0) ? S_HALT : S_RD2;
      S_RD2:  if (desc_rvalid_i) state_d = S_WAIT;
      S_WAIT: if (grant) state_d = S_SEND;
      S_SEND: if (chk_ready_i) state_d = chk_eop_o ? S_DONE : S_WAIT;
      S_DONE: if (!done_full_i) state_d = S_POLL;
      S_HALT: state_d = S_HALT;
      default: state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_INIT;
      handle_q <= '0;
      base_q   <= '0;
      len_q    <= '0;
      chan_q   <= '0;
      off_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_POLL && pend_valid_i) handle_q <= pend_handle_i;
      if (desc_rvalid_i) begin
        if (state_q == S_RD0) base_q <= {desc_rdata_i[ADDR_W-1:3], 3'b000};
        if (state_q == S_RD1) begin
          len_q <= desc_rdata_i;
          off_q <= '0;
        end
        if (state_q == S_RD2) chan_q <= desc_rdata_i;
      end
      if (fire) off_q <= off_q + 32'(chk_size_o);
    end
  end

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o && !chk_ready_i |=> chk_valid_o && $stable(chk_addr_o) &&
    $stable(chk_ctrl_o) && $stable(chk_slot_o) && $stable(chk_size_o));

  p_size_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o |-> chk_size_o != '0 && chk_size_o <= SIZE_W'(CHUNK_BYTES));

  p_mid_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o && !chk_eop_o |-> chk_size_o == SIZE_W'(CHUNK_BYTES));

  p_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o |-> chk_addr_o[2:0] == 3'b000);

  p_slot_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> chk_slot_o == SLOT_W'($past(chk_slot_o) + 1'b1));

  p_eop_then_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && chk_eop_o |=> !chk_valid_o && !pend_ready_o);

  p_irq_room_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> !done_full_i);

  p_halt_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_HALT |=> state_q == S_HALT && !pend_ready_o && !chk_valid_o);
endmodule

// File: tb/chunk_segmenter_bench.sv
module chunk_segmenter_bench;
  typedef struct packed {
    logic [31:0] addr;
    logic [6:0]  size;
    logic [2:0]  words;
    logic [6:0]  slot;
    logic        sop;
    logic        eop;
    logic [31:0] ctrl;
    logic [15:0] caddr;
  } chunk_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  seq_i = 8'hF5;
  logic        pend_valid_i = 1'b0;
  logic [31:0] pend_handle_i = '0;
  logic        pend_ready_o;
  logic        desc_req_o;
  logic [31:0] desc_addr_o;
  logic        desc_rvalid_i = 1'b0;
  logic [31:0] desc_rdata_i = '0;
  logic        chk_valid_o;
  logic        chk_ready_i = 1'b0;
  logic [31:0] chk_addr_o;
  logic [6:0]  chk_size_o;
  logic [2:0]  chk_words_o;
  logic [6:0]  chk_slot_o;
  logic        chk_sop_o, chk_eop_o;
  logic [31:0] chk_ctrl_o;
  logic [15:0] chk_ctrl_addr_o;
  logic        done_full_i = 1'b0;
  logic        done_valid_o;
  logic [31:0] done_handle_o;
  logic        host_irq_o;

  chunk_segmenter u_chunk_segmenter (.*);

  always #4 clk_i = ~clk_i;

  int vectors = 0, errors = 0;
  logic [31:0] d_addr [16], d_len [16], d_ch [16];
  chunk_t      exp_q [$];
  logic [31:0] pend_q [$], done_q [$];
  int          next_slot = 8'hF5 % 128;
  int          issued = 0, transmitted = 0, eop_cnt = 0, done_cnt = 0;
  logic [31:0] cur_handle = '0;
  int          widx = 0;
  bit          run = 0, ready_rand = 0, full_rand = 0, tx_hold = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        nxt_rvalid = 1'b0;
  logic [31:0] nxt_rdata = '0;
  bit          prev_stall = 0;
  chunk_t      prev_cmd;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    int k = int'(a >> 8) - 1;
    case ((a & 32'hFF) >> 2)
      0:       return d_addr[k];
      1:       return d_len[k];
      default: return d_ch[k];
    endcase
  endfunction

  task automatic add_desc(input int k, input logic [31:0] a, input logic [31:0] len,
                          input logic [31:0] ch);
    int off = 0;
    d_addr[k] = a; d_len[k] = len; d_ch[k] = ch;
    pend_q.push_back(32'h100 * (k + 1));
    if (len == 0) return;
    while (off < int'(len)) begin
      chunk_t c;
      int rem = int'(len) - off;
      int sz = (rem <= 64) ? rem : 64;
      c.sop   = (off == 0);
      c.eop   = (rem <= 64);
      c.size  = 7'(sz);
      c.words = 3'((sz - 1) >> 3);
      c.addr  = (a & ~32'h7) + 32'(off);
      c.slot  = 7'(next_slot);
      c.caddr = 16'h1800 + 16'(next_slot * 8);
      c.ctrl  = ch | (32'({c.sop, c.eop}) << 8) | (32'(sz) << 24);
      exp_q.push_back(c);
      next_slot = (next_slot + 1) % 128;
      off += sz;
    end
    done_q.push_back(32'h100 * (k + 1));
  endtask

  task automatic monitor();
    chunk_t got;
    got = '{chk_addr_o, chk_size_o, chk_words_o, chk_slot_o, chk_sop_o, chk_eop_o,
            chk_ctrl_o, chk_ctrl_addr_o};
    check(host_irq_o == done_valid_o && !(done_valid_o && done_full_i),
          "R9 irq/push vs full", {host_irq_o, done_valid_o}, {done_valid_o, 1'b0});
    if (prev_stall)
      check(chk_valid_o && got == prev_cmd, "R12 held command", got[31:0], prev_cmd[31:0]);
    if (pend_ready_o && pend_valid_i && pend_q.size() > 0) begin
      logic [31:0] h = pend_q.pop_front();
      if (h != 0) begin cur_handle = h; widx = 0; end
    end
    nxt_rvalid = 1'b0;
    if (desc_req_o && !desc_rvalid_i) begin
      check(desc_addr_o == cur_handle + 32'(4 * widx) && widx < 3,
            "R1/R2 descriptor address", desc_addr_o, cur_handle + 32'(4 * widx));
      widx++;
      nxt_rvalid = 1'b1;
      nxt_rdata  = mem_rd(desc_addr_o);
    end
    if (chk_valid_o && chk_ready_i) begin
      check(issued - transmitted <= 96, "R8 in-flight at issue",
            32'(issued - transmitted), 32'd96);
      if (exp_q.size() == 0) check(0, "R10 unexpected chunk", got[31:0], 0);
      else begin
        chunk_t e = exp_q.pop_front();
        check(got.addr == e.addr, "R4 addr", got.addr, e.addr);
        check({got.size, got.sop, got.eop} == {e.size, e.sop, e.eop}, "R3 size/flags",
              {got.size, got.sop, got.eop}, {e.size, e.sop, e.eop});
        check({got.slot, got.caddr} == {e.slot, e.caddr}, "R5 slot/ctrl addr",
              {got.slot, got.caddr}, {e.slot, e.caddr});
        check(got.ctrl == e.ctrl, "R6 ctrl word", got.ctrl, e.ctrl);
        check(got.words == e.words, "R7 words", got.words, e.words);
      end
      issued++;
      if (chk_eop_o) eop_cnt++;
    end
    if (done_valid_o) begin
      logic [31:0] eh = (done_q.size() > 0) ? done_q[0] : 32'hDEAD;
      check(done_cnt < eop_cnt && done_handle_o == eh, "R9 completion handle",
            done_handle_o, eh);
      if (done_q.size() > 0) void'(done_q.pop_front());
      done_cnt++;
    end
    prev_stall = chk_valid_o && !chk_ready_i;
    prev_cmd   = got;
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      if (run) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        chk_ready_i   = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
        done_full_i   = full_rand ? (lfsr[2] | lfsr[5]) : 1'b0;
        if (!tx_hold && transmitted < issued && lfsr[1]) transmitted++;
        seq_i         = 8'(8'hF5 + transmitted);
        pend_valid_i  = 1'b1;
        pend_handle_i = (pend_q.size() > 0) ? pend_q[0] : 32'h0;
        desc_rvalid_i = nxt_rvalid;
        desc_rdata_i  = nxt_rdata;
        #3;
        monitor();
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0 || done_cnt != eop_cnt || pend_q.size() != 0)
      @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check({chk_valid_o, pend_ready_o, desc_req_o, done_valid_o, host_irq_o} == 5'b0,
          "R11 reset outputs",
          {chk_valid_o, pend_ready_o, desc_req_o, done_valid_o, host_irq_o}, 0);
    rst_ni = 1'b1;
    run = 1;
    // Phase 1: mixed lengths, random ready and completion-full, zero handles interleaved
    ready_rand = 1; full_rand = 1;
    add_desc(0, 32'h1000_0000, 64, 3);
    pend_q.push_back(0);
    pend_q.push_back(0);
    add_desc(1, 32'h2000_0005, 130, 7);
    add_desc(2, 32'h3000_0040, 1, 32'h21);
    pend_q.push_back(0);
    add_desc(3, 32'h4000_0008, 65, 1);
    add_desc(4, 32'h5000_0000, 128, 8'hFE);
    add_desc(5, 32'h6000_0100, 300, 5);
    drain();
    // Phase 2: freeze the sequence counter so the tracker must stall at 97 (R8)
    ready_rand = 0; full_rand = 0; tx_hold = 1;
    add_desc(6, 32'h7000_0000, 6400, 2);
    repeat (700) @(negedge clk_i);
    check(issued - transmitted == 97, "R8 stall level", 32'(issued - transmitted), 32'd97);
    tx_hold = 0;
    drain();
    // Phase 3: zero length halts the engine (R10)
    add_desc(7, 32'h8000_0000, 0, 0);
    add_desc(8, 32'h9000_0000, 64, 4);
    repeat (100) @(negedge clk_i);
    check(pend_q.size() == 1, "R10 queue untouched after halt", pend_q.size(), 1);
    check(exp_q.size() == 1, "R10 no chunk after halt", exp_q.size(), 1);
    check(!pend_ready_o, "R10 pend_ready low", pend_ready_o, 0);
    finish_run();
  end
endmodule